// File: doc/BRIEF.md
# Multicycle 16-bit Load/Store Processor Core

This block is a small processor that repeatedly fetches an instruction from one word-addressed memory, decodes it and executes it. Code and data share that memory. The core holds sixteen 16-bit general registers and a program counter. Register 0 always reads as zero.

Every instruction starts with one word made of four 4-bit fields. Instructions that need an address or a constant take a second word. The core supports:
- arithmetic: add, subtract, negate and multiply
- signed comparisons, which write a boolean 0 or 1 into a register
- register loads and stores
- two conditional jumps that test a register for exactly 1 or exactly 0
- an unconditional jump

Every memory or jump address is the constant word plus an index register.

The memory port is synchronous. The core drives an address, write data and a write enable. Read data for an address presented at one clock edge is returned by the next edge, and a write happens at the edge where the enable is high. A subroutine-call opcode, a return opcode or an all-zero opcode stops the core and raises `halted`, and it then stays idle until reset. The intended use is to preload memory with a program and data, release reset, wait for `halted`, and inspect memory.

Top module: `mc16_core`

## Requirements
- R1: On synchronous reset the PC and every register are cleared. `halted` is low and `mem_we` is low. After release the first fetch is from address 0, and any register read before being written gives 0.
- R2: The first word holds the opcode in bits [15:12], field u in [11:8], field v in [7:4] and field w in [3:0]. Opcodes 1, 2, 7, b, c and d take the next word as their constant, and execution continues at the word after that constant.
- R3: Opcode 2 copies the constant word into Ru. Register 0 always reads 0, and writes aimed at it are dropped.
- R4: Opcode 3 writes Rv+Rw into Ru, opcode 4 writes Rv−Rw, opcode 5 writes −Rv, and opcode 6 writes Rv×Rw. Each result keeps only its low 16 bits.
- R5: Opcode 8 tests equality, opcode 9 tests less-than and opcode a tests greater-than, all with Rv and Rw taken as signed two's complement. Each writes 1 into Ru when the relation holds and 0 when it does not.
- R6: Opcode 1 loads Ru from memory, and opcode 7 stores Ru to memory. The address is the constant plus Rv, wrapping modulo 2^16.
- R7: Opcode b jumps to the constant plus Rv when Ru is exactly 1. Opcode c makes the same jump when Ru is exactly 0. Any other value of Ru falls through to the next instruction.
- R8: Opcode d always jumps to the constant plus Ru.
- R9: Opcodes 0, e and f raise `halted`. It then stays high, and no memory write occurs until reset.
- R10: A loop that sums 1..n from memory and a scan that finds the signed maximum of a terminated array both leave the correct result in memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |
| halted | output | 1 | Core has stopped |

## Verification
Each arithmetic and compare opcode is driven through a short program with operand pairs chosen to separate correct behaviour from near misses:
- a sum that wraps
- a negative difference
- a product beyond 16 bits
- negating the most negative value
- compares where the signed and unsigned orderings disagree
- compares of equal operands

Jump programs place a store on each path, so a taken jump and a fall-through leave different memory contents. The jump tests use a condition register holding 2 to show that only exact 0 or 1 count. Index-register tests use an index of −1 to show that address arithmetic wraps. A jump indexed through field u shows that the index comes from the correct field. Whole programs, a counted sum and an array maximum that includes negative entries, confirm that the sequencing holds over many iterations.

// File: rtl/mc16_pkg.sv
package mc16_pkg;

   typedef enum logic [3:0] {
      OP_STOP = 4'h0,
      OP_LD   = 4'h1,
      OP_LDI  = 4'h2,
      OP_ADD  = 4'h3,
      OP_SUB  = 4'h4,
      OP_NEG  = 4'h5,
      OP_MUL  = 4'h6,
      OP_ST   = 4'h7,
      OP_EQ   = 4'h8,
      OP_LT   = 4'h9,
      OP_GT   = 4'hA,
      OP_BRT  = 4'hB,
      OP_BRF  = 4'hC,
      OP_JMP  = 4'hD,
      OP_SUBR = 4'hE,
      OP_RTN  = 4'hF
   } op_e;

   typedef enum logic [2:0] {
      ST_FETCH,
      ST_DECODE,
      ST_OPND,
      ST_EXEC,
      ST_LDWB,
      ST_HALT
   } state_e;

   function automatic logic has_ext(input op_e op);
      return op inside {OP_LD, OP_LDI, OP_ST, OP_BRT, OP_BRF, OP_JMP};
   endfunction

   function automatic logic is_stop(input op_e op);
      return op inside {OP_STOP, OP_SUBR, OP_RTN};
   endfunction

   function automatic logic is_cmp(input op_e op);
      return op inside {OP_EQ, OP_LT, OP_GT};
   endfunction

   function automatic logic writes_alu(input op_e op);
      return op inside {OP_ADD, OP_SUB, OP_NEG, OP_MUL, OP_EQ, OP_LT, OP_GT};
   endfunction

endpackage

// File: rtl/mc16_regfile.sv
module mc16_regfile #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned SEL_W  = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [SEL_W-1:0]  rd_sel_a,
   input  logic [SEL_W-1:0]  rd_sel_b,
   input  logic [SEL_W-1:0]  rd_sel_c,
   output logic [DATA_W-1:0] rd_data_a,
   output logic [DATA_W-1:0] rd_data_b,
   output logic [DATA_W-1:0] rd_data_c
);

   localparam int unsigned NUM_REGS = 1 << SEL_W;

   logic [NUM_REGS-1:0][DATA_W-1:0] bank;

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      if (g == 0) begin : g_zero
         assign bank[g] = '0;
      end else begin : g_ff
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk) begin
            if (rst)
               q <= '0;
            else if (wr_en && wr_sel == SEL_W'(g))
               q <= wr_data;
         end
         assign bank[g] = q;
      end
   end

   assign rd_data_a = bank[rd_sel_a];
   assign rd_data_b = bank[rd_sel_b];
   assign rd_data_c = bank[rd_sel_c];

   // R3
   wr_land_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_sel != '0) |=> (bank[$past(wr_sel)] == $past(wr_data)));

   // R3
   r0_write_drop_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_sel == '0 && rd_sel_a == '0) |-> (rd_data_a == '0));

endmodule

// File: rtl/mc16_alu.sv
module mc16_alu
   import mc16_pkg::*;
#(
   parameter int unsigned DATA_W     = 16,
   parameter bit          SIGNED_CMP = 1'b1
) (
   input  op_e               op,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   output logic [DATA_W-1:0] res
);

   logic eq_r, lt_r, gt_r;

   assign eq_r = (opa == opb);

   if (SIGNED_CMP) begin : g_scmp
      assign lt_r = ($signed(opa) < $signed(opb));
      assign gt_r = ($signed(opa) > $signed(opb));
   end else begin : g_ucmp
      assign lt_r = (opa < opb);
      assign gt_r = (opa > opb);
   end

   always_comb begin
      case (op)
         OP_ADD:  res = opa + opb;
         OP_SUB:  res = opa - opb;
         OP_NEG:  res = '0 - opa;
         OP_MUL:  res = opa * opb;
         OP_EQ:   res = {{(DATA_W-1){1'b0}}, eq_r};
         OP_LT:   res = {{(DATA_W-1){1'b0}}, lt_r};
         OP_GT:   res = {{(DATA_W-1){1'b0}}, gt_r};
         default: res = '0;
      endcase
   end

endmodule

// File: rtl/mc16_seq.sv
module mc16_seq
   import mc16_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [DATA_W-1:0]      mem_rdata,
   input  logic [DATA_W-1:0]      val_u,
   input  logic [DATA_W-1:0]      val_v,
   input  logic [DATA_W-1:0]      alu_res,
   output logic [DATA_W-1:0]      mem_addr,
   output logic [DATA_W-1:0]      mem_wdata,
   output logic                   mem_we,
   output logic                   halted,
   output logic [DATA_W/4-1:0]    sel_u,
   output logic [DATA_W/4-1:0]    sel_v,
   output logic [DATA_W/4-1:0]    sel_w,
   output op_e                    op,
   output logic                   rf_we,
   output logic [DATA_W-1:0]      rf_wdata
);

   localparam int unsigned FIELD_W = DATA_W / 4;

   state_e            state, nxt_state;
   logic [DATA_W-1:0] pc, nxt_pc;
   logic [DATA_W-1:0] ir;
   logic [DATA_W-1:0] ext;
   logic [DATA_W-1:0] pc_inc;
   logic [DATA_W-1:0] ea;
   op_e               fetched_op;

   function automatic op_e decode_op(input logic [DATA_W-1:0] word);
      logic [FIELD_W-1:0] f;
      f = word[DATA_W-1 -: FIELD_W];
      if ((f >> 4) != '0)
         return OP_STOP;
      return op_e'(f[3:0]);
   endfunction

   assign op         = decode_op(ir);
   assign fetched_op = decode_op(mem_rdata);
   assign sel_u      = ir[DATA_W-FIELD_W-1 -: FIELD_W];
   assign sel_v      = ir[2*FIELD_W-1 -: FIELD_W];
   assign sel_w      = ir[FIELD_W-1:0];
   assign pc_inc     = pc + DATA_W'(1);
   assign ea         = ext + ((op == OP_JMP) ? val_u : val_v);
   assign halted     = (state == ST_HALT);

   always_comb begin
      nxt_state = state;
      nxt_pc    = pc;
      mem_addr  = pc;
      mem_we    = 1'b0;
      mem_wdata = val_u;
      rf_we     = 1'b0;
      rf_wdata  = alu_res;
      case (state)
         ST_FETCH: begin
            nxt_state = ST_DECODE;
         end
         ST_DECODE: begin
            mem_addr = pc_inc;
            if (is_stop(fetched_op)) begin
               nxt_state = ST_HALT;
            end else if (has_ext(fetched_op)) begin
               nxt_pc    = pc + DATA_W'(2);
               nxt_state = ST_OPND;
            end else begin
               nxt_pc    = pc_inc;
               nxt_state = ST_EXEC;
            end
         end
         ST_OPND: begin
            nxt_state = ST_EXEC;
         end
         ST_EXEC: begin
            nxt_state = ST_FETCH;
            case (op)
               OP_LD: begin
                  mem_addr  = ea;
                  nxt_state = ST_LDWB;
               end
               OP_LDI: begin
                  rf_we    = 1'b1;
                  rf_wdata = ext;
               end
               OP_ST: begin
                  mem_addr = ea;
                  mem_we   = 1'b1;
               end
               OP_BRT: if (val_u == DATA_W'(1)) nxt_pc = ea;
               OP_BRF: if (val_u == '0) nxt_pc = ea;
               OP_JMP: nxt_pc = ea;
               default: rf_we = writes_alu(op);
            endcase
         end
         ST_LDWB: begin
            rf_we     = 1'b1;
            rf_wdata  = mem_rdata;
            nxt_state = ST_FETCH;
         end
         ST_HALT: begin
            nxt_state = ST_HALT;
         end
         default: nxt_state = ST_HALT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_FETCH;
         pc    <= '0;
         ir    <= '0;
         ext   <= '0;
      end else begin
         state <= nxt_state;
         pc    <= nxt_pc;
         if (state == ST_DECODE) ir  <= mem_rdata;
         if (state == ST_OPND)   ext <= mem_rdata;
      end
   end

   // R9
   halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      halted |=> (halted && !mem_we));

   // R5
   cmp_bool_chk: assert property (@(posedge clk) disable iff (rst)
      (state == ST_EXEC && is_cmp(op)) |-> ((alu_res >> 1) == '0));

   // R7
   brt_fall_chk: assert property (@(posedge clk) disable iff (rst)
      (state == ST_EXEC && op == OP_BRT && val_u != DATA_W'(1)) |=> (pc == $past(pc)));

   // R7
   brf_fall_chk: assert property (@(posedge clk) disable iff (rst)
      (state == ST_EXEC && op == OP_BRF && val_u != '0) |=> (pc == $past(pc)));

   // R2
   ext_capture_chk: assert property (@(posedge clk) disable iff (rst)
      (state == ST_OPND) |=> (ext == $past(mem_rdata)));

endmodule

// File: rtl/mc16_core.sv
module mc16_core
   import mc16_pkg::*;
#(
   parameter int unsigned DATA_W     = 16,
   parameter bit          SIGNED_CMP = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   output logic [DATA_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              halted
);

   localparam int unsigned FIELD_W = DATA_W / 4;

   if ((DATA_W % 4) != 0 || DATA_W < 16) begin : g_bad_width
      $error("mc16_core: DATA_W must be a multiple of 4 and at least 16");
   end

   logic [FIELD_W-1:0] sel_u, sel_v, sel_w;
   logic [DATA_W-1:0]  val_u, val_v, val_w;
   logic [DATA_W-1:0]  alu_res;
   logic [DATA_W-1:0]  rf_wdata;
   logic               rf_we;
   op_e                op;

   mc16_seq #(.DATA_W(DATA_W)) seq_i (
      .clk       (clk),
      .rst       (rst),
      .mem_rdata (mem_rdata),
      .val_u     (val_u),
      .val_v     (val_v),
      .alu_res   (alu_res),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_we    (mem_we),
      .halted    (halted),
      .sel_u     (sel_u),
      .sel_v     (sel_v),
      .sel_w     (sel_w),
      .op        (op),
      .rf_we     (rf_we),
      .rf_wdata  (rf_wdata)
   );

   mc16_regfile #(.DATA_W(DATA_W), .SEL_W(FIELD_W)) rf_i (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (rf_we),
      .wr_sel    (sel_u),
      .wr_data   (rf_wdata),
      .rd_sel_a  (sel_u),
      .rd_sel_b  (sel_v),
      .rd_sel_c  (sel_w),
      .rd_data_a (val_u),
      .rd_data_b (val_v),
      .rd_data_c (val_w)
   );

   mc16_alu #(.DATA_W(DATA_W), .SIGNED_CMP(SIGNED_CMP)) alu_i (
      .op  (op),
      .opa (val_v),
      .opb (val_w),
      .res (alu_res)
   );

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      rst |=> (!halted && !mem_we));

endmodule

// File: tb/mc16_core_tb_top.sv
module mc16_core_tb_top;

   localparam int CLK_HALF = 10;
   localparam int NV       = 14;
   localparam int LIMIT    = 10000;

   // {opcode, operand a, operand b, expected result}
   localparam logic [51:0] VEC [NV] = '{
      {4'h3, 16'h0005, 16'h0007, 16'h000C},
      {4'h3, 16'hFFFF, 16'h0002, 16'h0001},
      {4'h4, 16'h0003, 16'h0005, 16'hFFFE},
      {4'h5, 16'h0005, 16'h0000, 16'hFFFB},
      {4'h5, 16'h8000, 16'h0000, 16'h8000},
      {4'h6, 16'd300,  16'd300,  16'h5F90},
      {4'h6, 16'hFFFE, 16'h0003, 16'hFFFA},
      {4'h8, 16'h0009, 16'h0009, 16'h0001},
      {4'h8, 16'h0009, 16'h0008, 16'h0000},
      {4'h9, 16'hFFFF, 16'h0001, 16'h0001},
      {4'h9, 16'h0001, 16'hFFFF, 16'h0000},
      {4'h9, 16'h0004, 16'h0004, 16'h0000},
      {4'hA, 16'h7FFF, 16'h8000, 16'h0001},
      {4'hA, 16'h0004, 16'h0004, 16'h0000}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] mem_addr, mem_wdata, mem_rdata;
   logic        mem_we, halted;
   logic [15:0] mem [256];
   int          wp;
   int          n_chk = 0;
   int          n_bad = 0;

   always #(CLK_HALF) clk = ~clk;

   // synchronous memory: data for an address appears after the next edge
   always @(posedge clk) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[7:0]];
   end

   mc16_core dut_i (
      .clk       (clk),
      .rst       (rst),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_we    (mem_we),
      .mem_rdata (mem_rdata),
      .halted    (halted)
   );

   function automatic logic [15:0] ins(input int op, input int u, input int v, input int w);
      return {op[3:0], u[3:0], v[3:0], w[3:0]};
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 256; i++) mem[i] = 16'hDEAD;
      wp = 0;
   endtask

   task automatic put(input logic [15:0] w);
      mem[wp[7:0]] = w;
      wp++;
   endtask

   task automatic start_reset();
      rst = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic run_to_halt(input string req);
      rst = 1'b0;
      for (int c = 0; c < LIMIT; c++) begin
         @(negedge clk);
         if (halted) break;
      end
      if (!halted) chk({req, " halt reached"}, 16'(halted), 16'h0001);
   endtask

   initial begin
      #(2 * CLK_HALF * 200000);
      n_bad++;
      $display("FAIL R9 watchdog: actual running expected halted");
      report();
   end

   initial begin
      // ---- table of arithmetic / compare vectors ----
      for (int i = 0; i < NV; i++) begin
         logic [3:0]  vop;
         logic [15:0] va, vb, vexp;
         {vop, va, vb, vexp} = VEC[i];
         clear_mem();
         put(ins(2, 1, 0, 0)); put(va);
         put(ins(2, 2, 0, 0)); put(vb);
         if (vop == 4'h5) put(ins(5, 3, 1, 0));
         else             put(ins(int'(vop), 3, 1, 2));
         put(ins(7, 3, 0, 0)); put(16'h00F0);
         put(16'h0000);
         start_reset();
         run_to_halt("R9");
         if (vop >= 4'h3 && vop <= 4'h6) chk($sformatf("R4 vector %0d", i), mem[8'hF0], vexp);
         else                            chk($sformatf("R5 vector %0d", i), mem[8'hF0], vexp);
      end

      // ---- R1: reset clears registers and the PC ----
      clear_mem();
      put(ins(2, 5, 0, 0)); put(16'h1234); put(16'h0000);
      start_reset();
      run_to_halt("R9");
      clear_mem();
      put(ins(7, 5, 0, 0)); put(16'h00F0); put(16'h0000);
      start_reset();
      #1;
      chk("R1 halted in reset", 16'(halted), 16'h0000);
      chk("R1 mem_we in reset", 16'(mem_we), 16'h0000);
      chk("R1 first fetch address", mem_addr, 16'h0000);
      run_to_halt("R9");
      chk("R1 register cleared", mem[8'hF0], 16'h0000);

      // ---- R3 / R2: constant load and register 0 ----
      clear_mem();
      put(ins(2, 0, 0, 0)); put(16'h1234);
      put(ins(3, 1, 0, 0));
      put(ins(7, 1, 0, 0)); put(16'h00F0);
      put(ins(7, 0, 0, 0)); put(16'h00F1);
      put(ins(2, 2, 0, 0)); put(16'hABCD);
      put(ins(7, 2, 0, 0)); put(16'h00F2);
      put(16'h0000);
      start_reset();
      run_to_halt("R9");
      chk("R3 sum of R0", mem[8'hF0], 16'h0000);
      chk("R3 R0 write dropped", mem[8'hF1], 16'h0000);
      chk("R2 R3 constant word", mem[8'hF2], 16'hABCD);

      // ---- R6: indexed load and store ----
      clear_mem();
      mem[8'h90] = 16'h4242;
      put(ins(2, 1, 0, 0)); put(16'h0003);
      put(ins(2, 2, 0, 0)); put(16'h1111);
      put(ins(7, 2, 1, 0)); put(16'h0080);
      put(ins(1, 4, 1, 0)); put(16'h008D);
      put(ins(7, 4, 0, 0)); put(16'h00F0);
      put(ins(2, 5, 0, 0)); put(16'hFFFF);
      put(ins(7, 2, 5, 0)); put(16'h00A1);
      put(16'h0000);
      start_reset();
      run_to_halt("R9");
      chk("R6 indexed store", mem[8'h83], 16'h1111);
      chk("R6 indexed load", mem[8'hF0], 16'h4242);
      chk("R6 index wraps", mem[8'hA0], 16'h1111);

      // ---- R7: conditional jumps ----
      clear_mem();
      put(ins(2, 1, 0, 0)); put(16'h0002);
      put(ins(11, 1, 0, 0)); put(16'h0010);
      put(ins(2, 7, 0, 0)); put(16'h0001);
      put(ins(7, 7, 0, 0)); put(16'h00F0);
      put(ins(12, 1, 0, 0)); put(16'h0010);
      put(ins(7, 7, 0, 0)); put(16'h00F1);
      put(ins(12, 0, 0, 0)); put(16'h0010);
      put(ins(7, 7, 0, 0)); put(16'h00F2);
      put(ins(11, 7, 7, 0)); put(16'h0013);
      put(ins(7, 7, 0, 0)); put(16'h00F3);
      put(16'h0000);
      start_reset();
      run_to_halt("R9");
      chk("R7 true-jump on 2 falls through", mem[8'hF0], 16'h0001);
      chk("R7 false-jump on 2 falls through", mem[8'hF1], 16'h0001);
      chk("R7 false-jump on 0 taken", mem[8'hF2], 16'hDEAD);
      chk("R7 true-jump on 1 taken with index", mem[8'hF3], 16'hDEAD);

      // ---- R8: unconditional jump indexed through field u ----
      clear_mem();
      put(ins(2, 3, 0, 0)); put(16'h0004);
      put(ins(13, 3, 0, 0)); put(16'h0006);
      put(ins(7, 3, 0, 0)); put(16'h00F0);
      put(ins(7, 3, 0, 0)); put(16'h00F1);
      put(16'h0000); put(16'h0000);
      put(ins(7, 3, 0, 0)); put(16'h00F2);
      put(16'h0000);
      start_reset();
      run_to_halt("R9");
      chk("R8 skipped word 4", mem[8'hF0], 16'hDEAD);
      chk("R8 skipped word 6", mem[8'hF1], 16'hDEAD);
      chk("R8 target reached", mem[8'hF2], 16'h0004);

      // ---- R9: stop opcodes ----
      clear_mem();
      put(ins(2, 1, 0, 0)); put(16'h0005);
      put(16'hE000);
      put(ins(7, 1, 0, 0)); put(16'h00F0);
      put(16'h0000);
      start_reset();
      run_to_halt("R9");
      begin
         int we_cnt = 0;
         for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (mem_we) we_cnt++;
         end
         chk("R9 halted stays high", 16'(halted), 16'h0001);
         chk("R9 no write after halt", 16'(we_cnt), 16'h0000);
         chk("R9 next store not executed", mem[8'hF0], 16'hDEAD);
      end
      clear_mem();
      put(16'hF000);
      start_reset();
      run_to_halt("R9");
      chk("R9 return opcode halts", 16'(halted), 16'h0001);

      // ---- R10: sum of 1..200 ----
      clear_mem();
      mem[8'h80] = 16'd200;
      put(ins(2, 2, 0, 0)); put(16'h0000);
      put(ins(2, 5, 0, 0)); put(16'h0001);
      put(ins(1, 1, 0, 0)); put(16'h0080);
      put(ins(10, 4, 1, 0));
      put(ins(12, 4, 0, 0)); put(16'h000D);
      put(ins(3, 2, 2, 1));
      put(ins(4, 1, 1, 5));
      put(ins(13, 0, 0, 0)); put(16'h0006);
      put(ins(7, 2, 0, 0)); put(16'h0081);
      put(16'h0000);
      start_reset();
      run_to_halt("R10");
      chk("R10 sum 1..200", mem[8'h81], 16'h4E84);

      // ---- R10: signed maximum of a terminated array ----
      clear_mem();
      mem[8'hA0] = 16'hFFF0; mem[8'hA1] = 16'h0005; mem[8'hA2] = 16'hFFFD;
      mem[8'hA3] = 16'h0011; mem[8'hA4] = 16'h0009; mem[8'hA5] = 16'hFFFF;
      put(ins(2, 3, 0, 0)); put(16'hFFFF);
      put(ins(2, 4, 0, 0)); put(16'h0001);
      put(ins(1, 1, 0, 0)); put(16'h00A0);
      put(ins(2, 2, 0, 0)); put(16'h0001);
      put(ins(1, 5, 2, 0)); put(16'h00A0);
      put(ins(8, 6, 5, 3));
      put(ins(11, 6, 0, 0)); put(16'h0014);
      put(ins(10, 7, 5, 1));
      put(ins(12, 7, 0, 0)); put(16'h0011);
      put(ins(3, 1, 5, 0));
      put(ins(3, 2, 2, 4));
      put(ins(13, 0, 0, 0)); put(16'h0008);
      put(ins(7, 1, 0, 0)); put(16'h0082);
      put(16'h0000);
      start_reset();
      run_to_halt("R10");
      chk("R10 array maximum", mem[8'h82], 16'h0011);

      report();
   end

endmodule